// File: doc/BRIEF.md
# Link and Activity Status Indicators

This block drives the three active-low status indicators of a dual-speed twisted-pair transceiver: one for traffic, one for a good 100 Mb/s link and one for a good 10 Mb/s link. All of its inputs are synchronous to one system clock. They are single-cycle strobes for transmit activity, receive activity, a detected normal link pulse and a received valid 10BASE-T packet, plus the internal 100 Mb/s signal-detect level.

The traffic indicator is stretched so that a single-cycle strobe stays visible. The 100 Mb/s indicator uses a three-state machine. `L100_DOWN` moves to `L100_QUAL` on the first sample of signal detect. `L100_QUAL` moves to `L100_UP` once signal detect has been sampled high for the qualification time, and drops back to `L100_DOWN` on any low sample, which discards the partial count. `L100_UP` returns to `L100_DOWN` on the first low sample. The 10 Mb/s indicator uses a two-state machine. `L10_DOWN` counts link pulses that follow each other within a spacing window. It moves to `L10_UP` on the seventh such pulse, or at once on a valid packet. `L10_UP` reloads a loss timer on every pulse or packet and returns to `L10_DOWN` when that timer runs out.

All times are set in physical units: the clock in Hz, the qualification time in µs, and the pulse spacing, loss time and stretch time in ms. Cycle counts are derived from these. The qualification time must come to at least two cycles.

Top module: `link_status_led`

## Requirements
- R1: Each output drives 0 when its condition is true and 1 otherwise. While `rst` is sampled high, all three outputs are 1 and both links are down, whatever the other inputs do.
- R2: `led_act_n` is 0 in the cycle after any cycle in which `tx_act` or `rx_act` is sampled high.
- R3: `led_act_n` stays 0 for exactly STRETCH cycles after the last sampled strobe, where STRETCH = CLK_HZ*STRETCH_MS/1000. A new strobe restarts this interval.
- R4: `led_100_n` goes to 0 only after `sig_det` has been sampled high on QUAL consecutive edges, where QUAL = CLK_HZ*QUAL_US/1e6. It is 0 right after the QUAL-th such edge and 1 after the (QUAL-1)-th.
- R5: `led_100_n` goes to 1 in the cycle after `sig_det` is sampled low. Any partial qualification is discarded, so the next qualification needs a full QUAL samples again.
- R6: From link-down, `led_10_n` goes to 0 on the LINK_PULSES-th (default 7) consecutive `lnk_pulse`. Pulses are consecutive when each arrives no more than GAP = CLK_HZ*GAP_MS/1000 cycles after the one before it.
- R7: A pulse that arrives more than GAP cycles after the previous one restarts the count at one.
- R8: From link-down, `led_10_n` goes to 0 in the cycle after `pkt_ok` is sampled high.
- R9: Once the 10 Mb/s link is up, it goes down (`led_10_n` = 1) exactly LOSS = CLK_HZ*LOSS_MS/1000 cycles after the last sampled `lnk_pulse` or `pkt_ok`. Each such event restarts the timer.
- R10: All timing windows scale with CLK_HZ as given in R3, R4, R6 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| sig_det | input | 1 | Internal 100 Mb/s signal-detect level |
| lnk_pulse | input | 1 | Normal link pulse detected, one cycle |
| pkt_ok | input | 1 | Valid 10BASE-T packet received, one cycle |
| led_act_n | output | 1 | Activity indicator, active low |
| led_100_n | output | 1 | 100 Mb/s link indicator, active low |
| led_10_n | output | 1 | 10 Mb/s link indicator, active low |

## Verification
Every output comes straight from a state register, so each result appears in the cycle after the edge that samples its cause. The activity indicator turns on one cycle after a strobe and turns off STRETCH cycles after it. The 100 Mb/s indicator turns on after the QUAL-th high sample and turns off one cycle after a low sample. The 10 Mb/s indicator turns on one cycle after the qualifying pulse or packet and turns off LOSS cycles after the last event. The bench queues one expected item per driven cycle, tagged with a mask of the outputs due in that cycle, and the monitor pops it shortly after the following rising edge. In this way the check falls exactly in the cycle each result is due, including the cycle just before it, which is checked against the opposite value.

// File: rtl/led_status_pkg.sv
package led_status_pkg;

    typedef enum logic [1:0] {
        L100_DOWN,
        L100_QUAL,
        L100_UP
    } l100_state_t;

    typedef enum logic {
        L10_DOWN,
        L10_UP
    } l10_state_t;

    // amount is in units of 1/per_sec seconds
    function automatic int unsigned to_cycles(input int unsigned hz,
                                              input int unsigned amount,
                                              input int unsigned per_sec);
        longint unsigned prod;
        prod = longint'(hz) * longint'(amount);
        return 32'(prod / longint'(per_sec));
    endfunction

endpackage

// File: rtl/led_act_stretch.sv
module led_act_stretch #(
    parameter int unsigned HOLD_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_act,
    input  logic rx_act,
    output logic led_n
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (tx_act || rx_act)
            hold_q <= HW'(HOLD_CYC);
        else if (hold_q != '0)
            hold_q <= hold_q - 1'b1;
    end

    assign led_n = (hold_q == '0);

    // R2
    act_on_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_act || rx_act) |=> !led_n);

    // R3
    act_off_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(led_n) |-> $past(!tx_act && !rx_act));

endmodule

// File: rtl/led_link100_fsm.sv
module led_link100_fsm
    import led_status_pkg::*;
#(
    parameter int unsigned QUAL_CYC = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_det,
    output logic led_n
);
    localparam int QW = $clog2(QUAL_CYC + 1);

    l100_state_t   state_q, state_d;
    logic [QW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= L100_DOWN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            L100_DOWN: begin
                if (sig_det) begin
                    state_d = L100_QUAL;
                    cnt_d   = QW'(1);
                end
            end
            L100_QUAL: begin
                if (!sig_det) begin
                    state_d = L100_DOWN;
                    cnt_d   = '0;
                end else if (cnt_q == QW'(QUAL_CYC - 1)) begin
                    state_d = L100_UP;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            L100_UP: begin
                if (!sig_det)
                    state_d = L100_DOWN;
            end
            default: begin
                state_d = L100_DOWN;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        led_n = (state_q != L100_UP);
    end

    // R5
    l100_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !sig_det |=> led_n);

    // R4
    l100_qual_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(led_n) |-> ($past(sig_det) && $past(sig_det, 2)));

endmodule

// File: rtl/led_link10_fsm.sv
module led_link10_fsm
    import led_status_pkg::*;
#(
    parameter int unsigned PULSES   = 7,
    parameter int unsigned GAP_CYC  = 20,
    parameter int unsigned LOSS_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic lnk_pulse,
    input  logic pkt_ok,
    output logic led_n
);
    localparam int PW = $clog2(PULSES + 1);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int LW = $clog2(LOSS_CYC + 1);

    l10_state_t    state_q, state_d;
    logic [PW-1:0] pcnt_q, pcnt_d;
    logic [GW-1:0] gap_q, gap_d;
    logic [LW-1:0] loss_q, loss_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= L10_DOWN;
            pcnt_q  <= '0;
            gap_q   <= '0;
            loss_q  <= '0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
            gap_q   <= gap_d;
            loss_q  <= loss_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pcnt_d  = pcnt_q;
        loss_d  = loss_q;
        gap_d   = (gap_q != '0) ? gap_q - 1'b1 : '0;
        if (lnk_pulse)
            gap_d = GW'(GAP_CYC);
        unique case (state_q)
            L10_DOWN: begin
                if (pkt_ok) begin
                    state_d = L10_UP;
                    loss_d  = LW'(LOSS_CYC);
                    pcnt_d  = '0;
                end else if (lnk_pulse) begin
                    if (gap_q == '0) begin
                        pcnt_d = PW'(1);
                    end else if (pcnt_q == PW'(PULSES - 1)) begin
                        state_d = L10_UP;
                        loss_d  = LW'(LOSS_CYC);
                        pcnt_d  = '0;
                    end else begin
                        pcnt_d = pcnt_q + 1'b1;
                    end
                end
            end
            L10_UP: begin
                if (lnk_pulse || pkt_ok) begin
                    loss_d = LW'(LOSS_CYC);
                end else if (loss_q == LW'(1)) begin
                    state_d = L10_DOWN;
                    loss_d  = '0;
                    pcnt_d  = '0;
                end else begin
                    loss_d = loss_q - 1'b1;
                end
            end
            default: begin
                state_d = L10_DOWN;
                pcnt_d  = '0;
                loss_d  = '0;
            end
        endcase
    end

    always_comb begin
        led_n = (state_q != L10_UP);
    end

    // R8
    l10_pkt_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_ok |=> !led_n);

    // R9
    l10_loss_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(led_n) |-> $past(!lnk_pulse && !pkt_ok));

    // R6
    l10_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(led_n) |-> $past(lnk_pulse || pkt_ok));

endmodule

// File: rtl/link_status_led.sv
module link_status_led
    import led_status_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 25_000_000,
    parameter int unsigned QUAL_US     = 500,
    parameter int unsigned GAP_MS      = 150,
    parameter int unsigned LOSS_MS     = 100,
    parameter int unsigned STRETCH_MS  = 50,
    parameter int unsigned LINK_PULSES = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_act,
    input  logic rx_act,
    input  logic sig_det,
    input  logic lnk_pulse,
    input  logic pkt_ok,
    output logic led_act_n,
    output logic led_100_n,
    output logic led_10_n
);
    // R10
    localparam int unsigned QUAL_CYC    = to_cycles(CLK_HZ, QUAL_US, 1_000_000);
    localparam int unsigned GAP_CYC     = to_cycles(CLK_HZ, GAP_MS, 1_000);
    localparam int unsigned LOSS_CYC    = to_cycles(CLK_HZ, LOSS_MS, 1_000);
    localparam int unsigned STRETCH_CYC = to_cycles(CLK_HZ, STRETCH_MS, 1_000);

    led_act_stretch #(
        .HOLD_CYC (STRETCH_CYC)
    ) act_u (
        .clk    (clk),
        .rst    (rst),
        .tx_act (tx_act),
        .rx_act (rx_act),
        .led_n  (led_act_n)
    );

    led_link100_fsm #(
        .QUAL_CYC (QUAL_CYC)
    ) l100_u (
        .clk     (clk),
        .rst     (rst),
        .sig_det (sig_det),
        .led_n   (led_100_n)
    );

    led_link10_fsm #(
        .PULSES   (LINK_PULSES),
        .GAP_CYC  (GAP_CYC),
        .LOSS_CYC (LOSS_CYC)
    ) l10_u (
        .clk       (clk),
        .rst       (rst),
        .lnk_pulse (lnk_pulse),
        .pkt_ok    (pkt_ok),
        .led_n     (led_10_n)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (led_act_n && led_100_n && led_10_n));

endmodule

// File: tb/link_status_led_tb_top.sv
module link_status_led_tb_top;

    localparam int S = 10;  // stretch cycles: 10 kHz * 1 ms
    localparam int Q = 5;   // qualify cycles: 10 kHz * 500 us
    localparam int G = 20;  // pulse spacing: 10 kHz * 2 ms
    localparam int L = 50;  // loss cycles: 10 kHz * 5 ms

    localparam logic [2:0] NONE = 3'b000;
    localparam logic [2:0] MA   = 3'b100;
    localparam logic [2:0] M1   = 3'b010;
    localparam logic [2:0] M0   = 3'b001;

    typedef struct {
        logic [2:0] mask;
        logic [2:0] exp;
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_act = 1'b0, rx_act = 1'b0, sig_det = 1'b0;
    logic lnk_pulse = 1'b0, pkt_ok = 1'b0;
    logic led_act_n, led_100_n, led_10_n;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    item_t exp_q[$];

    always #2 clk = ~clk;

    link_status_led #(
        .CLK_HZ     (10_000),
        .QUAL_US    (500),
        .GAP_MS     (2),
        .LOSS_MS    (5),
        .STRETCH_MS (1)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .tx_act    (tx_act),
        .rx_act    (rx_act),
        .sig_det   (sig_det),
        .lnk_pulse (lnk_pulse),
        .pkt_ok    (pkt_ok),
        .led_act_n (led_act_n),
        .led_100_n (led_100_n),
        .led_10_n  (led_10_n)
    );

    // driver: one queued item per driven cycle
    task automatic cyc(input logic r, input logic t, input logic x,
                       input logic s, input logic n, input logic p,
                       input logic [2:0] m, input logic [2:0] e,
                       input string tag);
        @(negedge clk);
        rst = r; tx_act = t; rx_act = x; sig_det = s; lnk_pulse = n; pkt_ok = p;
        exp_q.push_back('{mask: m, exp: e, tag: tag});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, NONE, 3'b111, "");
    endtask

    // monitor: pop after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                item_t it;
                logic [2:0] got;
                it  = exp_q.pop_front();
                got = {led_act_n, led_100_n, led_10_n};
                if (it.mask != NONE) begin
                    checks++;
                    if (((got ^ it.exp) & it.mask) != 3'b000) begin
                        failures++;
                        $display("FAIL %s actual=%b expected=%b mask=%b",
                                 it.tag, got, it.exp, it.mask);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset holds every output high despite active inputs
        for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 1, 1, 3'b111, 3'b111, "R1 reset");
        cyc(0, 0, 0, 0, 0, 0, 3'b111, 3'b111, "R1 after reset");
        idle(2);

        // R2/R3: single tx strobe
        cyc(0, 1, 0, 0, 0, 0, MA, 3'b011, "R2 tx strobe");
        for (int j = 1; j <= S; j++)
            cyc(0, 0, 0, 0, 0, 0, (j >= S - 1) ? MA : NONE,
                (j == S) ? 3'b111 : 3'b011, "R3 stretch");
        idle(2);

        // R2/R3: rx strobe with retrigger
        cyc(0, 0, 1, 0, 0, 0, MA, 3'b011, "R2 rx strobe");
        idle(4);
        cyc(0, 0, 1, 0, 0, 0, MA, 3'b011, "R3 retrigger");
        for (int j = 1; j <= S; j++)
            cyc(0, 0, 0, 0, 0, 0, (j >= S - 1) ? MA : NONE,
                (j == S) ? 3'b111 : 3'b011, "R3 restretch");
        idle(2);

        // R4/R10: qualification then R5 immediate drop
        for (int k = 0; k < Q; k++)
            cyc(0, 0, 0, 1, 0, 0, (k >= Q - 2) ? M1 : NONE,
                (k == Q - 1) ? 3'b101 : 3'b111, "R4 R10 qualify");
        cyc(0, 0, 0, 0, 0, 0, M1, 3'b111, "R5 drop");

        // R5: partial qualification discarded
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 1, 0, 0, M1, 3'b111, "R5 partial");
        cyc(0, 0, 0, 0, 0, 0, M1, 3'b111, "R5 abort");
        for (int k = 0; k < Q; k++)
            cyc(0, 0, 0, 1, 0, 0, (k >= Q - 2) ? M1 : NONE,
                (k == Q - 1) ? 3'b101 : 3'b111, "R5 requalify");
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 1, 0, 0, M1, 3'b101, "R4 held");
        cyc(0, 0, 0, 0, 0, 0, M1, 3'b111, "R5 drop again");
        idle(2);

        // R6: seven pulses at maximum spacing
        for (int p = 1; p <= 7; p++) begin
            cyc(0, 0, 0, 0, 1, 0, (p >= 6) ? M0 : NONE,
                (p == 7) ? 3'b110 : 3'b111, "R6 pulse count");
            if (p < 7) idle(G - 1);
        end
        // R9: loss after last pulse
        for (int j = 1; j <= L; j++)
            cyc(0, 0, 0, 0, 0, 0, (j >= L - 1) ? M0 : NONE,
                (j == L) ? 3'b111 : 3'b110, "R9 loss");
        idle(2);

        // R7: late pulse restarts count
        for (int p = 1; p <= 3; p++) begin
            cyc(0, 0, 0, 0, 1, 0, M0, 3'b111, "R7 early pulses");
            idle(G - 1);
        end
        idle(1);
        for (int p = 1; p <= 7; p++) begin
            cyc(0, 0, 0, 0, 1, 0, (p >= 6) ? M0 : NONE,
                (p == 7) ? 3'b110 : 3'b111, "R7 count after late");
            if (p < 7) idle(G - 1);
        end
        // R9: packet restarts loss timer
        for (int j = 0; j < 30; j++) cyc(0, 0, 0, 0, 0, 0, M0, 3'b110, "R9 up");
        cyc(0, 0, 0, 0, 0, 1, M0, 3'b110, "R9 packet reload");
        for (int j = 1; j <= L; j++)
            cyc(0, 0, 0, 0, 0, 0, (j >= L - 1) ? M0 : NONE,
                (j == L) ? 3'b111 : 3'b110, "R9 reload loss");
        idle(3);

        // R8: valid packet from link-down
        cyc(0, 0, 0, 0, 0, 0, M0, 3'b111, "R8 before");
        cyc(0, 0, 0, 0, 0, 1, M0, 3'b110, "R8 packet up");
        for (int j = 1; j <= L; j++)
            cyc(0, 0, 0, 0, 0, 0, (j >= L - 1) ? M0 : NONE,
                (j == L) ? 3'b111 : 3'b110, "R9 loss after packet");

        idle(3);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule